// File: doc/BRIEF.md
# Programmable SPI Master Byte Exchanger

This block is the master side of a serial peripheral link. Software writes one byte into the data buffer, and that write is enough to start a full-duplex exchange. The byte goes out on the serial output, most significant bit first. At the same time a byte is gathered from the serial input. When the eighth bit is finished, the gathered byte replaces the buffer contents and a sticky interrupt flag goes high.

The bit rate comes from one of three fixed divisions of the system clock, or from a pulse supplied by an external timer; in the last case each pulse advances half a bit. Three configuration inputs set the serial clock's idle level, whether output data leads the first clock edge of a bit or changes on it, and whether input is captured mid-bit or at the end of the bit. A separate enable turns the output driver off. The exchange still runs and the received byte is still delivered, so the master can act as a line monitor. A write that arrives while an exchange is running is refused and raises a collision flag.

Top module: `spi_master_top`

## Requirements
- R1: A write while `busy` is low starts an exchange: on the next cycle `busy` is high and `rd_data` shows the written byte.
- R2: Output bits leave most significant bit first, one bit per bit time, bit 7 during the first bit time and bit 0 during the last.
- R3: `cfg_rate` encoding: 0 gives a bit time of 4 system clocks, 1 gives 16, 2 gives 64, and 3 makes each cycle with `tmr_tick` high advance the exchange by half a bit. Each bit time is two equal halves.
- R4: While no exchange runs, `sclk` equals `cfg_cpol` (the idle level). During an exchange the active level is the inverse.
- R5: With `cfg_cke`=1, `sdo` settles at the start of a bit while `sclk` is idle, `sclk` turns active at mid-bit and returns to idle at the end of the bit. With `cfg_cke`=0, `sclk` turns active at the start of each bit in the same cycle that `sdo` changes, and returns to idle at mid-bit.
- R6: With `cfg_smp`=0, `sdi` is captured at the end of the first half of each bit. With `cfg_smp`=1, it is captured at the end of the second half. Captured bits fill the received byte from the most significant end.
- R7: When the last half ends, `rd_data` takes the received byte and `ifg` rises in the same cycle. `ifg` stays high until a cycle with `clr_ifg` high, and a new completion wins over a clear in the same cycle.
- R8: `sdo_oe` follows `cfg_sdo_en`. With the output disabled, exchanges still run at the programmed rate and deliver the received byte and `ifg` exactly as usual.
- R9: A write while `busy` is high is refused: the running exchange and `rd_data` are unaffected, and `wcol` goes high until `clr_wcol`.
- R10: `busy` stays high from the cycle after the accepted write until the received byte is in `rd_data`. Afterwards `sclk` is at idle and `sdo` holds the last bit sent until the next exchange.
- R11: After reset, `sclk` is at idle, `sdo` is 0, `busy`, `ifg` and `wcol` are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Byte to send |
| rd_data | output | DATA_W | Buffer contents (written or received byte) |
| clr_ifg | input | 1 | Clears the completion flag |
| clr_wcol | input | 1 | Clears the collision flag |
| cfg_rate | input | 2 | Bit clock source select |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cke | input | 1 | Output leads the first clock edge when 1 |
| cfg_smp | input | 1 | Capture at end of bit when 1, mid-bit when 0 |
| cfg_sdo_en | input | 1 | Serial output driver enable |
| tmr_tick | input | 1 | External timer pulse for rate 3 |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | output | 1 | Exchange in progress |
| ifg | output | 1 | Completion flag |
| wcol | output | 1 | Write collision flag |

## Verification
The bench's serial slave changes `sdi` every half bit, not every bit. A design that captured in the wrong half, or that ignored `cfg_smp`, therefore assembles a different byte and is caught through `rd_data`. Every pairing of polarity and edge mode is run, so a clock that starts on the wrong level, makes one edge too many or too few, or fails to return to idle shows up as a mismatch of `sclk` in the cycle where it happens. A second write is placed in the middle of an exchange. If the design accepted it, the exchange would restart or `rd_data` would be corrupted; if it ignored it silently, `wcol` would stay low. The timer-driven rate uses irregular pulse spacing, so a design that counted clocks instead of pulses drifts out of step.

// File: rtl/spi_mstr_pkg.sv
package spi_mstr_pkg;

   typedef enum logic [1:0] {
      RATE_FAST = 2'd0,
      RATE_MID  = 2'd1,
      RATE_SLOW = 2'd2,
      RATE_TMR  = 2'd3
   } rate_sel_e;

   typedef struct packed {
      rate_sel_e rate;
      logic      cpol;
      logic      cke;
      logic      smp;
      logic      sdo_en;
   } spi_cfg_t;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick
   import spi_mstr_pkg::*;
#(
   parameter int DIV_FAST = 4,
   parameter int DIV_MID  = 16,
   parameter int DIV_SLOW = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  rate_sel_e rate,
   input  logic      tmr_tick,
   output logic      tick
);

   localparam int HALF_F   = DIV_FAST / 2;
   localparam int HALF_M   = DIV_MID / 2;
   localparam int HALF_S   = DIV_SLOW / 2;
   localparam int MAX_FM   = (HALF_F > HALF_M) ? HALF_F : HALF_M;
   localparam int MAX_HALF = (MAX_FM > HALF_S) ? MAX_FM : HALF_S;
   localparam int CNT_W    = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;
   localparam int NUM_DIV  = 3;
   localparam int HALF_T [NUM_DIV] = '{HALF_F, HALF_M, HALF_S};

   // elaboration checks on the divider set
   generate
      for (genvar c = 0; c < NUM_DIV; c++) begin : g_chk
         if (HALF_T[c] < 1) begin : g_bad
            $error("spi_half_tick: every divider must be at least 2");
         end
      end
      if ((DIV_FAST % 2) != 0 || (DIV_MID % 2) != 0 || (DIV_SLOW % 2) != 0) begin : g_odd
         $error("spi_half_tick: dividers must be even");
      end
   endgenerate

   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_DIV-1:0] hit;

   // one terminal comparator per fixed divider
   generate
      for (genvar g = 0; g < NUM_DIV; g++) begin : g_hit
         assign hit[g] = (cnt_q >= CNT_W'(HALF_T[g] - 1));
      end
   endgenerate

   always_comb begin
      case (rate)
         RATE_FAST: tick = run & hit[0];
         RATE_MID:  tick = run & hit[1];
         RATE_SLOW: tick = run & hit[2];
         default:   tick = run & tmr_tick;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick || rate == RATE_TMR) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // the half-bit counter never runs past the longest half period
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < MAX_HALF);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              cke,
   input  logic              smp,
   input  logic              sdi,
   output logic              busy,
   output logic              sclk_act,
   output logic              sdo,
   output logic              finish,
   output logic [DATA_W-1:0] rx_next
);

   localparam int HALVES = 2 * DATA_W;
   localparam int HW     = $clog2(HALVES + 1);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("spi_shift_engine: DATA_W must be at least 2");
      end
   endgenerate

   logic              busy_q;
   logic [HW-1:0]     hcnt_q;
   logic [DATA_W-1:0] tx_sh_q;
   logic [DATA_W-1:0] rx_sh_q;
   logic              act_q;
   logic              sdo_q;

   logic first_half;
   logic last_half;
   logic capture;
   logic accept;

   assign accept     = start & ~busy_q;
   assign first_half = ~hcnt_q[0];
   assign last_half  = (hcnt_q == HW'(HALVES - 1));
   assign capture    = busy_q & tick & (first_half ? ~smp : smp);
   assign rx_next    = capture ? {rx_sh_q[DATA_W-2:0], sdi} : rx_sh_q;
   assign finish     = busy_q & tick & ~first_half & last_half;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         hcnt_q  <= '0;
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         act_q   <= 1'b0;
         sdo_q   <= 1'b0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         hcnt_q  <= '0;
         tx_sh_q <= tx_byte;
         rx_sh_q <= '0;
         sdo_q   <= tx_byte[DATA_W-1];
         act_q   <= ~cke;
      end else if (busy_q && tick) begin
         rx_sh_q <= rx_next;
         hcnt_q  <= hcnt_q + 1'b1;
         if (first_half) begin
            act_q <= ~act_q;
         end else if (last_half) begin
            busy_q <= 1'b0;
            act_q  <= 1'b0;
         end else begin
            act_q   <= ~cke;
            tx_sh_q <= tx_sh_q << 1;
            sdo_q   <= tx_sh_q[DATA_W-2];
         end
      end
   end

   assign busy     = busy_q;
   assign sclk_act = act_q;
   assign sdo      = sdo_q;

   // an accepted start opens a fresh exchange at half zero
   assert_start_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_q && hcnt_q == '0));

   // an exchange ends only after all halves have elapsed
   assert_full_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (hcnt_q == HW'(HALVES)));

   // the clock is never left active once idle
   assert_idle_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> !act_q);

endmodule

// File: rtl/spi_master_top.sv
module spi_master_top
   import spi_mstr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_FAST = 4,
   parameter int DIV_MID  = 16,
   parameter int DIV_SLOW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              clr_ifg,
   input  logic              clr_wcol,
   input  logic [1:0]        cfg_rate,
   input  logic              cfg_cpol,
   input  logic              cfg_cke,
   input  logic              cfg_smp,
   input  logic              cfg_sdo_en,
   input  logic              tmr_tick,
   input  logic              sdi,
   output logic              sclk,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              busy,
   output logic              ifg,
   output logic              wcol
);

   spi_cfg_t cfg;
   assign cfg = '{rate: rate_sel_e'(cfg_rate), cpol: cfg_cpol, cke: cfg_cke,
                  smp: cfg_smp, sdo_en: cfg_sdo_en};

   logic              eng_busy;
   logic              tick;
   logic              act;
   logic              eng_sdo;
   logic              finish;
   logic [DATA_W-1:0] rx_next;
   logic              start;

   assign start = wr_en & ~eng_busy;

   spi_half_tick #(
      .DIV_FAST(DIV_FAST),
      .DIV_MID (DIV_MID),
      .DIV_SLOW(DIV_SLOW)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (eng_busy),
      .rate    (cfg.rate),
      .tmr_tick(tmr_tick),
      .tick    (tick)
   );

   spi_shift_engine #(
      .DATA_W(DATA_W)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tx_byte (wr_data),
      .tick    (tick),
      .cke     (cfg.cke),
      .smp     (cfg.smp),
      .sdi     (sdi),
      .busy    (eng_busy),
      .sclk_act(act),
      .sdo     (eng_sdo),
      .finish  (finish),
      .rx_next (rx_next)
   );

   logic [DATA_W-1:0] buf_q;
   logic              ifg_q;
   logic              wcol_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q  <= '0;
         ifg_q  <= 1'b0;
         wcol_q <= 1'b0;
      end else begin
         if (start) begin
            buf_q <= wr_data;
         end else if (finish) begin
            buf_q <= rx_next;
         end
         if (finish) begin
            ifg_q <= 1'b1;
         end else if (clr_ifg) begin
            ifg_q <= 1'b0;
         end
         if (wr_en && eng_busy) begin
            wcol_q <= 1'b1;
         end else if (clr_wcol) begin
            wcol_q <= 1'b0;
         end
      end
   end

   assign rd_data = buf_q;
   assign ifg     = ifg_q;
   assign wcol    = wcol_q;
   assign busy    = eng_busy;
   assign sclk    = cfg.cpol ^ act;
   assign sdo     = eng_sdo;
   assign sdo_oe  = cfg.sdo_en;

   // completion and flag raise happen together
   assert_flag_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ifg);

   // collision flag only rises after a write during an exchange
   assert_wcol_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol) |-> $past(wr_en && busy));

   // a refused write leaves the buffer alone
   assert_refused_keeps_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy && !finish) |=> $stable(rd_data));

   // serial output holds between exchanges
   assert_sdo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy && !wr_en)) |-> $stable(sdo));

   // idle clock level follows the polarity control
   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cfg_cpol));

endmodule

// File: tb/tb_spi_master_top.sv
module tb_spi_master_top;

   localparam int DF = 4;
   localparam int DM = 16;
   localparam int DS = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       clr_ifg = 1'b0;
   logic       clr_wcol = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cke = 1'b0;
   logic       cfg_smp = 1'b0;
   logic       cfg_sdo_en = 1'b1;
   logic       tmr_tick = 1'b0;
   logic       sdi;
   logic       sclk, sdo, sdo_oe, busy, ifg, wcol;

   int checks = 0;
   int bad = 0;
   logic cmp_on = 1'b0;
   logic [15:0] pat = 16'h0000;

   always #10 clk = ~clk;

   spi_master_top #(.DATA_W(8), .DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .clr_ifg(clr_ifg), .clr_wcol(clr_wcol), .cfg_rate(cfg_rate), .cfg_cpol(cfg_cpol),
      .cfg_cke(cfg_cke), .cfg_smp(cfg_smp), .cfg_sdo_en(cfg_sdo_en), .tmr_tick(tmr_tick),
      .sdi(sdi), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .ifg(ifg), .wcol(wcol)
   );

   // behavioural reference
   logic       m_busy = 1'b0, m_ifg = 1'b0, m_wcol = 1'b0, m_started = 1'b0;
   int         m_h = 0, m_cyc = 0;
   logic [7:0] m_tx = 8'h00, m_rx = 8'h00, m_buf = 8'h00;
   int         half_len;
   logic       tk, fin;
   logic [7:0] rxn;

   // slave changes its line every half bit
   assign sdi = (m_busy && m_h < 16) ? pat[15 - m_h] : 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0; m_ifg <= 0; m_wcol <= 0; m_started <= 0;
         m_h <= 0; m_cyc <= 0; m_tx <= 0; m_rx <= 0; m_buf <= 0;
      end else begin
         half_len = (cfg_rate == 2'd0) ? DF/2 : (cfg_rate == 2'd1) ? DM/2 : DS/2;
         tk  = m_busy && ((cfg_rate == 2'd3) ? tmr_tick : (m_cyc >= half_len - 1));
         fin = 1'b0;
         if (wr_en && !m_busy) begin
            m_busy <= 1; m_h <= 0; m_cyc <= 0; m_tx <= wr_data;
            m_rx <= 0; m_buf <= wr_data; m_started <= 1;
         end else if (m_busy) begin
            if (tk) begin
               rxn = m_rx;
               if ((m_h % 2 == 0 && !cfg_smp) || (m_h % 2 == 1 && cfg_smp))
                  rxn = {m_rx[6:0], sdi};
               m_rx  <= rxn;
               m_cyc <= 0;
               m_h   <= m_h + 1;
               if (m_h == 15) begin
                  fin = 1'b1;
                  m_busy <= 0;
                  m_buf  <= rxn;
               end
            end else if (cfg_rate != 2'd3) begin
               m_cyc <= m_cyc + 1;
            end
         end
         if (wr_en && m_busy) m_wcol <= 1;
         else if (clr_wcol) m_wcol <= 0;
         if (fin) m_ifg <= 1;
         else if (clr_ifg) m_ifg <= 0;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         logic exp_act;
         int   bi;
         exp_act = m_busy && (cfg_cke ? (m_h % 2 == 1) : (m_h % 2 == 0));
         bi = (m_h / 2 > 7) ? 7 : m_h / 2;
         chk("R4/R5 sclk", {7'd0, sclk}, {7'd0, cfg_cpol ^ exp_act});
         chk("R2/R5 sdo", {7'd0, sdo}, {7'd0, m_started ? m_tx[7 - bi] : 1'b0});
         chk("R1/R10 busy", {7'd0, busy}, {7'd0, m_busy});
         chk("R6/R7 rd_data", rd_data, m_buf);
         chk("R7 ifg", {7'd0, ifg}, {7'd0, m_ifg});
         chk("R9 wcol", {7'd0, wcol}, {7'd0, m_wcol});
         chk("R8 sdo_oe", {7'd0, sdo_oe}, {7'd0, cfg_sdo_en});
      end
   end

   // irregular timer pulses for R3 rate 3
   initial begin
      int n = 0;
      forever begin
         @(negedge clk);
         n++;
         tmr_tick = (n % 5 == 0) || (n % 7 == 0);
      end
   end

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   task automatic wait_idle();
      int g = 0;
      while (busy && g < 5000) begin
         @(negedge clk);
         g++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic xfer(input logic [1:0] rate, input logic cpol, input logic cke,
                       input logic smp, input logic oe, input logic [7:0] d,
                       input logic [15:0] p);
      @(negedge clk);
      cfg_rate = rate; cfg_cpol = cpol; cfg_cke = cke; cfg_smp = smp; cfg_sdo_en = oe;
      pat = p;
      @(negedge clk);
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", {7'd0, busy}, 8'd0);
      chk("R11 sclk", {7'd0, sclk}, 8'd0);
      chk("R11 sdo", {7'd0, sdo}, 8'd0);
      chk("R11 rd_data", rd_data, 8'd0);
      chk("R11 flags", {6'd0, ifg, wcol}, 8'd0);
      rst_n = 1;
      @(negedge clk);
      cmp_on = 1;
      // R1 R2 R3 R5 R6: four polarity/edge pairings, every rate
      xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 16'hC3A9);
      xfer(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 16'hC3A9);
      clr_ifg = 1; @(negedge clk); clr_ifg = 0;          // R7 clear
      xfer(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 16'h5AF0);
      xfer(2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE7, 16'h936C);
      xfer(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h12, 16'h6B1D);
      // R8 receive with output disabled
      clr_ifg = 1; @(negedge clk); clr_ifg = 0;
      xfer(2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 16'hA55A);
      xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0FF0);
      // R9 collision mid-exchange
      cfg_sdo_en = 1; pat = 16'h1E2D;
      @(negedge clk); wr_en = 1; wr_data = 8'h5A;
      @(negedge clk); wr_en = 0;
      repeat (9) @(negedge clk);
      wr_en = 1; wr_data = 8'hC6;
      @(negedge clk); wr_en = 0;
      wait_idle();
      clr_wcol = 1; clr_ifg = 1; @(negedge clk); clr_wcol = 0; clr_ifg = 0;
      // R7 completion set wins over a clear held through the end
      pat = 16'hF00F;
      @(negedge clk); wr_en = 1; wr_data = 8'h96;
      @(negedge clk); wr_en = 0; clr_ifg = 1;
      wait_idle();
      clr_ifg = 0;
      repeat (4) @(negedge clk);
      cmp_on = 0;
      @(negedge clk);
      finish_up();
   end

endmodule